// File: doc/BRIEF.md
# Eight-Region Memory Protection Checker

This block decides, for every memory access, whether it may proceed. An access arrives with a 32-bit address, an access kind (read, write or instruction fetch) and a flag that marks it as coming from user or privileged code. The block compares the address with eight programmable protection windows. If no window matches, it reports a background miss. If a window matches, it takes that window's 4-bit permission code and decides whether the access is allowed. The verdict is registered and appears one clock after the request.

Software sets up the block through a single-cycle register write port. That port holds eight window registers, separate permission words for fetches and for data accesses, a control word whose bit 0 turns checking on, and an offset register. Low addresses are relocated by the offset before the check. No other translation is done, and the relocated address is returned beside the verdict. While checking is off, every access is allowed for both reading and writing.

Top module: `mem_prot_check`

## Requirements
- R1: When `reqValid` is high at a rising edge, `rspValid` is high after that edge and the other response outputs describe that request. When `reqValid` is low, `rspValid` is low after the edge. After reset, all outputs are 0.
- R2: While bit 0 of the control word (config select 10) is 0, every access gives `rspRdOk`=1, `rspWrOk`=1 and `rspFault`=0. Reset clears that bit.
- R3: A window register (config select 0..7 for windows 0..7) is active when its bit 0 is 1. Its bits 5:1 hold an exponent N, and the window covers 2^(N+1) bytes. An address hits the window when it equals the register on every bit above the low N+1 bits.
- R4: When checking is on and no active window is hit, the access faults with `rspFaultCode`=2.
- R5: When several active windows are hit, the one with the highest number decides.
- R6: For a fetch (`reqType`=2), window n uses bits 4n+3:4n of the fetch permission word (select 8). For a read (`reqType`=0) or a write (`reqType`=1), it uses the same bits of the data permission word (select 9).
- R7: Permission codes give these rights. Code 3: read and write for all. Code 6: read for all. Code 1: privileged read and write, user nothing. Code 2: privileged read and write, user read. Code 5: privileged read, user nothing. Codes 0, 4 and 7..15: nothing.
- R8: A write needs write rights. A read or a fetch needs read rights. An access without the rights it needs faults with `rspFaultCode`=1. With no fault, `rspRdOk` and `rspWrOk` show the granted rights and `rspFaultCode`=0. On any fault both flags are 0.
- R9: An address below 0x02000000 has the offset register (select 11) added to it before the window check. Higher addresses are unchanged. The offset applies whether checking is on or off, and the resulting address is returned on `rspAddr`.
- R10: A configuration write to select 12..15 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 4 | Configuration register select |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Access request present |
| reqAddr | input | 32 | Access address |
| reqType | input | 2 | 0 read, 1 write, 2 fetch (3 treated as read) |
| reqUser | input | 1 | 1 = user access, 0 = privileged |
| rspValid | output | 1 | Verdict valid |
| rspAddr | output | 32 | Address after offset relocation |
| rspRdOk | output | 1 | Read allowed |
| rspWrOk | output | 1 | Write allowed |
| rspFault | output | 1 | Access faults |
| rspFaultCode | output | 2 | 0 none, 1 permission denial, 2 background miss |

## Verification
Two overlapping windows are used: a 4 KB window over an all-memory window. Probes go just inside and just outside the small window's edges, so a wrong size mask or a wrong priority gives a different verdict. Every permission code is tried for both privilege levels with reads and writes, so user and privileged rights are told apart and read rights are told apart from write rights. Fetches and data accesses to the same window are given different permission words, which shows which word is used. Addresses on both sides of the 0x02000000 relocation limit are probed, with checking on and with checking off.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int NUM_REGIONS = 8;
  localparam int ADDR_W      = 32;
  localparam int PERM_W      = 4;
  localparam int REGION_IDX_W = $clog2(NUM_REGIONS);
  localparam int PERM_WORD_W = NUM_REGIONS * PERM_W;
  localparam int EXP_LSB     = 1;
  localparam int EXP_W       = 5;
  localparam logic [ADDR_W-1:0] RELOC_LIMIT = 32'h0200_0000;

  // config select codes
  localparam logic [3:0] SEL_FETCH_PERM = 4'd8;
  localparam logic [3:0] SEL_DATA_PERM  = 4'd9;
  localparam logic [3:0] SEL_CONTROL    = 4'd10;
  localparam logic [3:0] SEL_OFFSET     = 4'd11;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PERM = 2'd1,
    FLT_BG   = 2'd2
  } fault_code_e;

  typedef struct packed {
    logic [NUM_REGIONS-1:0] regionWe;
    logic                   fetchPermWe;
    logic                   dataPermWe;
    logic                   controlWe;
    logic                   offsetWe;
    logic                   capture;
  } cfg_strobe_t;

  typedef struct packed {
    logic rd;
    logic wr;
  } rights_t;

  function automatic rights_t decodePerm(input logic [PERM_W-1:0] code, input logic isUser);
    rights_t r;
    r = '0;
    unique case (code)
      4'd1: begin r.rd = !isUser; r.wr = !isUser; end
      4'd2: begin r.rd = 1'b1;    r.wr = !isUser; end
      4'd3: begin r.rd = 1'b1;    r.wr = 1'b1;    end
      4'd5: begin r.rd = !isUser; r.wr = 1'b0;    end
      4'd6: begin r.rd = 1'b1;    r.wr = 1'b0;    end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mpc_ctrl.sv
module mpc_ctrl
  import mpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [3:0]  cfgSel,
  input  logic        reqValid,
  output cfg_strobe_t strobes,
  output logic        rspValid
);
  always_comb begin
    strobes = '0;
    strobes.capture = reqValid;
    if (cfgWrEn) begin
      if (cfgSel < 4'(NUM_REGIONS)) begin
        strobes.regionWe[cfgSel[REGION_IDX_W-1:0]] = 1'b1;
      end else begin
        unique case (cfgSel)
          SEL_FETCH_PERM: strobes.fetchPermWe = 1'b1;
          SEL_DATA_PERM:  strobes.dataPermWe  = 1'b1;
          SEL_CONTROL:    strobes.controlWe   = 1'b1;
          SEL_OFFSET:     strobes.offsetWe    = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/mpc_datapath.sv
module mpc_datapath
  import mpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strobes,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqType,
  input  logic              reqUser,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspRdOk,
  output logic              rspWrOk,
  output logic              rspFault,
  output logic [1:0]        rspFaultCode
);
  logic [ADDR_W-1:0]      regionQ [NUM_REGIONS];
  logic [PERM_WORD_W-1:0] fetchPermQ;
  logic [PERM_WORD_W-1:0] dataPermQ;
  logic                   checkOnQ;
  logic [ADDR_W-1:0]      offsetQ;

  // configuration storage
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegionReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    regionQ[g] <= '0;
      else if (strobes.regionWe[g]) regionQ[g] <= cfgWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPermQ <= '0;
      dataPermQ  <= '0;
      checkOnQ   <= 1'b0;
      offsetQ    <= '0;
    end else begin
      if (strobes.fetchPermWe) fetchPermQ <= cfgWrData[PERM_WORD_W-1:0];
      if (strobes.dataPermWe)  dataPermQ  <= cfgWrData[PERM_WORD_W-1:0];
      if (strobes.controlWe)   checkOnQ   <= cfgWrData[0];
      if (strobes.offsetWe)    offsetQ    <= cfgWrData;
    end
  end

  // relocation of low addresses
  logic [ADDR_W-1:0] effAddr;
  assign effAddr = (reqAddr < RELOC_LIMIT) ? reqAddr + offsetQ : reqAddr;

  // per-window hit detection
  logic [NUM_REGIONS-1:0] hit;
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : gRegionHit
    logic [EXP_W-1:0]  expField;
    logic [63:0]       spanOnes;
    logic [ADDR_W-1:0] sizeMask;
    assign expField = regionQ[g][EXP_LSB +: EXP_W];
    assign spanOnes = (64'd1 << ({1'b0, expField} + 6'd1)) - 64'd1;
    assign sizeMask = spanOnes[ADDR_W-1:0];
    assign hit[g]   = regionQ[g][0] && (((regionQ[g] ^ effAddr) & ~sizeMask) == '0);
  end

  // fixed priority: the highest-numbered hit wins
  logic [REGION_IDX_W-1:0] winner;
  logic                    anyHit;
  always_comb begin
    winner = '0;
    anyHit = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit[i]) begin
        winner = REGION_IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  // permission lookup and verdict
  logic                   isFetch;
  logic                   isWrite;
  logic [PERM_WORD_W-1:0] permWord;
  logic [PERM_W-1:0]      permCode;
  rights_t                rights;
  logic                   nxtRd, nxtWr, nxtFault;
  logic [1:0]             nxtCode;

  assign isFetch  = (reqType == ACC_FETCH);
  assign isWrite  = (reqType == ACC_WRITE);
  assign permWord = isFetch ? fetchPermQ : dataPermQ;
  assign permCode = permWord[winner*PERM_W +: PERM_W];
  assign rights   = decodePerm(permCode, reqUser);

  always_comb begin
    nxtRd    = 1'b1;
    nxtWr    = 1'b1;
    nxtFault = 1'b0;
    nxtCode  = FLT_NONE;
    if (checkOnQ) begin
      if (!anyHit) begin
        nxtFault = 1'b1;
        nxtCode  = FLT_BG;
      end else if (isWrite ? !rights.wr : !rights.rd) begin
        nxtFault = 1'b1;
        nxtCode  = FLT_PERM;
      end else begin
        nxtRd = rights.rd;
        nxtWr = rights.wr;
      end
      if (nxtFault) begin
        nxtRd = 1'b0;
        nxtWr = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspAddr      <= '0;
      rspRdOk      <= 1'b0;
      rspWrOk      <= 1'b0;
      rspFault     <= 1'b0;
      rspFaultCode <= FLT_NONE;
    end else if (strobes.capture) begin
      rspAddr      <= effAddr;
      rspRdOk      <= nxtRd;
      rspWrOk      <= nxtWr;
      rspFault     <= nxtFault;
      rspFaultCode <= nxtCode;
    end
  end
endmodule

// File: rtl/mem_prot_check.sv
module mem_prot_check
  import mpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [3:0]  cfgSel,
  input  logic [31:0] cfgWrData,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  input  logic [1:0]  reqType,
  input  logic        reqUser,
  output logic        rspValid,
  output logic [31:0] rspAddr,
  output logic        rspRdOk,
  output logic        rspWrOk,
  output logic        rspFault,
  output logic [1:0]  rspFaultCode
);
  cfg_strobe_t strobes;

  mpc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .reqValid (reqValid),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  mpc_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .cfgWrData    (cfgWrData),
    .reqAddr      (reqAddr),
    .reqType      (reqType),
    .reqUser      (reqUser),
    .rspAddr      (rspAddr),
    .rspRdOk      (rspRdOk),
    .rspWrOk      (rspWrOk),
    .rspFault     (rspFault),
    .rspFaultCode (rspFaultCode)
  );
endmodule

// File: rtl/mem_prot_check_sva.sv
module mem_prot_check_sva (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic [1:0]  reqType,
  input logic        rspValid,
  input logic [31:0] rspAddr,
  input logic        rspRdOk,
  input logic        rspWrOk,
  input logic        rspFault,
  input logic [1:0]  rspFaultCode
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  assert_fault_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspFaultCode == 2'd1 || rspFaultCode == 2'd2));
  assert_no_fault_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rspFault |-> rspFaultCode == 2'd0);
  assert_fault_clears_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (!rspRdOk && !rspWrOk));
  assert_write_needs_wr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqType == 2'd1) |=> (rspFault || rspWrOk));
  assert_read_needs_rd_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqType != 2'd1) |=> (rspFault || rspRdOk));
  assert_high_addr_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= 32'h0200_0000) |=> rspAddr == $past(reqAddr));
endmodule

bind mem_prot_check mem_prot_check_sva u_sva (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqAddr      (reqAddr),
  .reqType      (reqType),
  .rspValid     (rspValid),
  .rspAddr      (rspAddr),
  .rspRdOk      (rspRdOk),
  .rspWrOk      (rspWrOk),
  .rspFault     (rspFault),
  .rspFaultCode (rspFaultCode)
);

// File: tb/mem_prot_check_tb.sv
module mem_prot_check_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqType = '0;
  logic        reqUser = 1'b0;
  logic        rspValid, rspRdOk, rspWrOk, rspFault;
  logic [31:0] rspAddr;
  logic [1:0]  rspFaultCode;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_prot_check u_dut (.*);

  task automatic cfgWrite(input logic [3:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic expectVerdict(input string tag, input logic rd, input logic wr,
                               input logic [1:0] code, input logic [31:0] addr);
    logic [36:0] got, exp;
    got = {rspValid, rspRdOk, rspWrOk, rspFault, rspFaultCode, rspAddr[30:0]};
    exp = {1'b1, rd, wr, code != 2'd0, code, addr[30:0]};
    checks++;
    if (got !== exp || rspAddr[31] !== addr[31]) begin
      failures++;
      $display("FAIL %s: got valid=%b rd=%b wr=%b fault=%b code=%0d addr=%h, expected rd=%b wr=%b code=%0d addr=%h",
               tag, rspValid, rspRdOk, rspWrOk, rspFault, rspFaultCode, rspAddr, rd, wr, code, addr);
    end
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic [1:0] t,
                        input logic u, input logic rd, input logic wr,
                        input logic [1:0] code, input logic [31:0] expAddr);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqType = t; reqUser = u;
    @(negedge clk);
    reqValid = 1'b0;
    expectVerdict(tag, rd, wr, code, expAddr);
  endtask

  task automatic testReset();
    checks++;
    if (rspValid !== 1'b0 || rspFault !== 1'b0 || rspRdOk !== 1'b0 || rspWrOk !== 1'b0 || rspAddr !== '0) begin
      failures++;
      $display("FAIL R1 reset: valid=%b fault=%b rd=%b wr=%b addr=%h expected all 0",
               rspValid, rspFault, rspRdOk, rspWrOk, rspAddr);
    end
  endtask

  task automatic testIdle();
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) begin
      failures++;
      $display("FAIL R1 idle: rspValid=%b expected 0", rspValid);
    end
  endtask

  task automatic testBypass();
    access("R2 bypass user write", 32'h4000_0800, WR, 1'b1, 1, 1, 2'd0, 32'h4000_0800);
    access("R2 bypass fetch", 32'h9000_0000, FE, 1'b1, 1, 1, 2'd0, 32'h9000_0000);
  endtask

  task automatic testBackground();
    cfgWrite(4'd10, 32'h1);
    access("R4 no windows", 32'h1000_0000, RD, 1'b0, 0, 0, 2'd2, 32'h1000_0000);
  endtask

  task automatic testWindows();
    cfgWrite(4'd0, 32'h0000_003F);   // window 0: all memory
    cfgWrite(4'd3, 32'h4000_0017);   // window 3: 4 KB at 0x40000000
    cfgWrite(4'd9, 32'h0000_6003);
    access("R3 inside small read", 32'h4000_0800, RD, 1'b1, 1, 0, 2'd0, 32'h4000_0800);
    access("R8 write read-only", 32'h4000_0800, WR, 1'b1, 0, 0, 2'd1, 32'h4000_0800);
    access("R3 top edge inside", 32'h4000_0FFF, RD, 1'b1, 1, 0, 2'd0, 32'h4000_0FFF);
    access("R3 just above", 32'h4000_1000, WR, 1'b1, 1, 1, 2'd0, 32'h4000_1000);
    access("R3 just below", 32'h3FFF_FFFF, WR, 1'b1, 1, 1, 2'd0, 32'h3FFF_FFFF);
  endtask

  task automatic testPriority();
    cfgWrite(4'd7, 32'h4000_0017);
    access("R5 window 7 code 0 wins", 32'h4000_0800, RD, 1'b0, 0, 0, 2'd1, 32'h4000_0800);
    cfgWrite(4'd9, 32'h3000_6003);
    access("R5 window 7 code 3 wins", 32'h4000_0800, WR, 1'b1, 1, 1, 2'd0, 32'h4000_0800);
    cfgWrite(4'd7, 32'h4000_0016);   // enable bit clear
    access("R3 disabled window ignored", 32'h4000_0800, WR, 1'b1, 0, 0, 2'd1, 32'h4000_0800);
  endtask

  task automatic testFetch();
    cfgWrite(4'd8, 32'h0000_3000);
    access("R6 fetch uses fetch word", 32'h4000_0800, FE, 1'b1, 1, 1, 2'd0, 32'h4000_0800);
    access("R6 fetch window 0 code 0", 32'h1000_0000, FE, 1'b0, 0, 0, 2'd1, 32'h1000_0000);
    access("R6 data read window 0", 32'h1000_0000, RD, 1'b1, 1, 1, 2'd0, 32'h1000_0000);
  endtask

  task automatic testCodes();
    cfgWrite(4'd9, 32'h0000_1003);
    access("R7 code1 priv write", 32'h4000_0800, WR, 1'b0, 1, 1, 2'd0, 32'h4000_0800);
    access("R7 code1 user read", 32'h4000_0800, RD, 1'b1, 0, 0, 2'd1, 32'h4000_0800);
    cfgWrite(4'd9, 32'h0000_2003);
    access("R7 code2 user read", 32'h4000_0800, RD, 1'b1, 1, 0, 2'd0, 32'h4000_0800);
    access("R7 code2 user write", 32'h4000_0800, WR, 1'b1, 0, 0, 2'd1, 32'h4000_0800);
    access("R7 code2 priv write", 32'h4000_0800, WR, 1'b0, 1, 1, 2'd0, 32'h4000_0800);
    cfgWrite(4'd9, 32'h0000_5003);
    access("R7 code5 priv read", 32'h4000_0800, RD, 1'b0, 1, 0, 2'd0, 32'h4000_0800);
    access("R7 code5 priv write", 32'h4000_0800, WR, 1'b0, 0, 0, 2'd1, 32'h4000_0800);
    access("R7 code5 user read", 32'h4000_0800, RD, 1'b1, 0, 0, 2'd1, 32'h4000_0800);
    cfgWrite(4'd9, 32'h0000_4003);
    access("R7 code4 priv read", 32'h4000_0800, RD, 1'b0, 0, 0, 2'd1, 32'h4000_0800);
    cfgWrite(4'd9, 32'h0000_7003);
    access("R7 code7 priv read", 32'h4000_0800, RD, 1'b0, 0, 0, 2'd1, 32'h4000_0800);
  endtask

  task automatic testOffset();
    cfgWrite(4'd9, 32'h0000_6003);
    cfgWrite(4'd11, 32'h4000_0000);
    access("R9 low addr relocated", 32'h0000_0800, RD, 1'b1, 1, 0, 2'd0, 32'h4000_0800);
    access("R9 relocated write denied", 32'h0000_0800, WR, 1'b1, 0, 0, 2'd1, 32'h4000_0800);
    access("R9 limit not relocated", 32'h0200_0800, WR, 1'b1, 1, 1, 2'd0, 32'h0200_0800);
    access("R9 just below limit", 32'h01FF_FFFF, WR, 1'b1, 1, 1, 2'd0, 32'h41FF_FFFF);
  endtask

  task automatic testIgnoredSel();
    for (int s = 12; s < 16; s++) cfgWrite(4'(s), 32'h0000_0000);
    access("R10 ignored selects", 32'h4000_0800, RD, 1'b1, 1, 0, 2'd0, 32'h4000_0800);
    access("R10 ignored selects write", 32'h4000_0800, WR, 1'b1, 0, 0, 2'd1, 32'h4000_0800);
  endtask

  task automatic testBypassAgain();
    cfgWrite(4'd0, 32'h0);
    access("R4 window 0 removed", 32'h1000_0000, RD, 1'b0, 0, 0, 2'd2, 32'h1000_0000);
    cfgWrite(4'd10, 32'h0);
    access("R2 checking off again", 32'h4000_0800, WR, 1'b1, 1, 1, 2'd0, 32'h4000_0800);
    access("R9 offset while off", 32'h0000_0010, RD, 1'b1, 1, 1, 2'd0, 32'h4000_0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testIdle();
    testBypass();
    testBackground();
    testWindows();
    testPriority();
    testFetch();
    testCodes();
    testOffset();
    testIgnoredSel();
    testBypassAgain();
    testIdle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule